// File: doc/BRIEF.md
# Codec Status and Capture Frame Serializer

This block drives the codec-to-controller data line of a five-wire audio codec link. It emits one frame of 256 bit clocks after each frame-sync rising edge. Each frame is a 16-bit tag slot followed by twelve 20-bit data slots, and every field is sent MSB first. The block fills the slots from its ports:
- the register access that the controller asked for in the previous frame, with the register file's read data;
- nine capture samples, routed to the capture slots according to a 2-bit channel mapping mode;
- the state of ten general-purpose pins, with an interrupt flag.

Every frame input is sampled on the same bit-clock edge that detects the sync rising edge, and the whole frame is held until it has been sent. A register read is therefore answered in the frame that follows its request. The caller presents the decoded command during frame N, and the block returns the index and the data in frame N+1. A write returns nothing. Each tag bit is set only when its slot carries real data.

Top module: `codec_frame_tx`

## Requirements
- R1: After a clock edge that samples `sync_i` high while it was low on the previous edge, `sdata_o` carries frame bit 255 after the next edge and one lower bit per edge after that, down to bit 0. `sdata_o` is 0 during reset and whenever no frame is being sent.
- R2: The tag slot occupies frame bits 255..240. In that slot, bit 15 is `codec_ready_i`, bit 15-s is the valid flag of slot s for s = 1..12, and bits 2..0 are zero.
- R3: When `cmd_valid_i` and `cmd_read_i` are both 1, slot 1 (frame bits 239..220) carries `cmd_index_i` in its bits 18..12 and zero in all its other bits, and the slot 1 tag bit is set.
- R4: For the same read condition, slot 2 (frame bits 219..200) carries `reg_rdata_i` in its bits 19..4 and zero in bits 3..0, and the slot 2 tag bit is set.
- R5: For a write (`cmd_read_i` = 0) or when no command is present, slots 1 and 2 are all zero and their tag bits are clear.
- R6: Capture slot 3+k, for k = 0..8, carries channel c = (k + `adc_mode_i`) mod 9. Channel c is taken from `adc_samples_i[18c+17:18c]`, placed in slot bits 19..2 with bits 1..0 zero. The slot's tag bit equals `adc_valid_i[c]`, and a slot whose tag is clear is all zero.
- R7: Slot 12 (frame bits 19..0) carries `gpio_pins_i` in bits 19..10 and `gpio_irq_i` in bit 0, with bits 9..1 zero. Its tag bit equals `gpio_valid_i`, and when that tag is clear the slot is all zero.
- R8: Frame inputs that change after the capturing edge have no effect on the frame being sent.
- R9: Holding `sync_i` high for several edges starts exactly one frame. Only a new low-to-high transition starts another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_i | input | 1 | Frame sync from the controller, synchronous to `clk` |
| codec_ready_i | input | 1 | Codec ready flag for tag bit 15 |
| cmd_valid_i | input | 1 | A register access was requested in the previous frame |
| cmd_read_i | input | 1 | 1 = read access, 0 = write access |
| cmd_index_i | input | 7 | Register index of the access |
| reg_rdata_i | input | 16 | Register file data for the read index |
| adc_mode_i | input | 2 | Channel-to-capture-slot rotation |
| adc_samples_i | input | 162 | Nine 18-bit two's-complement samples, channel c at bits 18c+17..18c |
| adc_valid_i | input | 9 | Per-channel sample valid |
| gpio_pins_i | input | 10 | Current general-purpose pin levels |
| gpio_irq_i | input | 1 | Pin wake-up or interrupt event flag |
| gpio_valid_i | input | 1 | Slot 12 carries pin status |
| sdata_o | output | 1 | Serial frame data to the controller |

## Verification
Call E0 the edge that samples the sync rising edge. The frame is captured at E0, and frame bit 255-j appears on `sdata_o` after edge E(1+j). Bit 255 therefore follows E1 and bit 0 follows E256, and the line returns to 0 after E257. The bench raises `sync_i` before E0 and reads exactly one bit at each falling edge from E1 to E256. It expects 0 at the falling edge just after E0 and at the falling edges after the frame, so a frame that starts or ends one edge early or late fails its slot comparisons. Inputs that must not matter are changed in the middle of the frame and at the falling edge after E0. Slot contents are then checked against the values sampled at E0.

// File: rtl/codec_tx_pkg.sv
package codec_tx_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 12;
  localparam int FRAME_W   = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CAP_FIRST = 3;
  localparam int NUM_CAP   = NUM_SLOTS - CAP_FIRST;
  localparam int IDX_W     = 7;
  localparam int DATA_W    = 16;
  localparam int SAMPLE_W  = 18;
  localparam int GPIO_W    = 10;
  localparam int MODE_W    = 2;

  // Frame bit index of the MSB of data slot s (1..NUM_SLOTS).
  function automatic int slot_msb(int s);
    return FRAME_W - TAG_W - 1 - (s - 1) * SLOT_W;
  endfunction
endpackage

// File: rtl/codec_cap_mux.sv
module codec_cap_mux
  import codec_tx_pkg::*;
#(
  parameter int NCAP = NUM_CAP,
  parameter int SW   = SAMPLE_W
) (
  input  logic [MODE_W-1:0]      mode_i,
  input  logic [NCAP*SW-1:0]     samples_i,
  input  logic [NCAP-1:0]        valid_i,
  output logic [NCAP*SLOT_W-1:0] slots_o,
  output logic [NCAP-1:0]        tags_o
);
  localparam int SEL_W = $clog2(NCAP);

  for (genvar k = 0; k < NCAP; k++) begin : g_slot
    logic [SEL_W-1:0] sel;
    logic [SW-1:0]    smp;
    always_comb begin
      sel = SEL_W'((k + int'(mode_i)) % NCAP);
      smp = samples_i[sel*SW +: SW];
      tags_o[k] = valid_i[sel];
      slots_o[k*SLOT_W +: SLOT_W] = tags_o[k] ? {smp, {(SLOT_W-SW){1'b0}}} : '0;
    end
  end
endmodule

// File: rtl/codec_frame_build.sv
module codec_frame_build
  import codec_tx_pkg::*;
(
  input  logic                      ready_i,
  input  logic                      cmd_valid_i,
  input  logic                      cmd_read_i,
  input  logic [IDX_W-1:0]          index_i,
  input  logic [DATA_W-1:0]         rdata_i,
  input  logic [NUM_CAP*SLOT_W-1:0] cap_slots_i,
  input  logic [NUM_CAP-1:0]        cap_tags_i,
  input  logic [GPIO_W-1:0]         gpio_i,
  input  logic                      irq_i,
  input  logic                      gpio_valid_i,
  output logic [FRAME_W-1:0]        frame_o
);
  logic                 rd_ok;
  logic [TAG_W-1:0]     tag;
  logic [SLOT_W-1:0]    slot_a [NUM_SLOTS];

  always_comb begin
    rd_ok = cmd_valid_i & cmd_read_i;
    slot_a[0] = rd_ok ? {1'b0, index_i, {(SLOT_W-1-IDX_W){1'b0}}} : '0;
    slot_a[1] = rd_ok ? {rdata_i, {(SLOT_W-DATA_W){1'b0}}} : '0;
    for (int k = 0; k < NUM_CAP; k++) slot_a[CAP_FIRST-1+k] = cap_slots_i[k*SLOT_W +: SLOT_W];
    slot_a[NUM_SLOTS-1] = gpio_valid_i ? {gpio_i, {(SLOT_W-GPIO_W-1){1'b0}}, irq_i} : '0;

    tag = '0;
    tag[TAG_W-1] = ready_i;
    tag[TAG_W-2] = rd_ok;
    tag[TAG_W-3] = rd_ok;
    for (int k = 0; k < NUM_CAP; k++) tag[TAG_W-1-CAP_FIRST-k] = cap_tags_i[k];
    tag[TAG_W-1-NUM_SLOTS] = gpio_valid_i;

    frame_o = '0;
    frame_o[FRAME_W-1 -: TAG_W] = tag;
    for (int s = 1; s <= NUM_SLOTS; s++) frame_o[slot_msb(s) -: SLOT_W] = slot_a[s-1];
  end
endmodule

// File: rtl/codec_frame_shifter.sv
module codec_frame_shifter #(
  parameter int FW = 256
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic [FW-1:0] frame_i,
  output logic          sdata_o
);
  localparam int CNT_W = $clog2(FW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FW - 1);

  logic             sync_q, busy_q, busy_d, sdata_q, sdata_d, start, en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FW-1:0]    shreg_q, shreg_d;

  always_comb begin
    start   = sync_i & ~sync_q;
    en      = start | busy_q;
    sdata_d = busy_q & shreg_q[FW-1];
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    if (start) begin
      shreg_d = frame_i;
      cnt_d   = '0;
      busy_d  = 1'b1;
    end else if (busy_q) begin
      shreg_d = {shreg_q[FW-2:0], 1'b0};
      cnt_d   = cnt_q + 1'b1;
      busy_d  = (cnt_q != LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b0;
      sdata_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      sync_q  <= sync_i;
      sdata_q <= sdata_d;
      if (en) begin
        busy_q  <= busy_d;
        cnt_q   <= cnt_d;
        shreg_q <= shreg_d;
      end
    end
  end

  assign sdata_o = sdata_q;

  // R1: an idle cycle drives the line low on the next edge
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_q |=> !sdata_o);
  // R1: the frame ends after its last bit unless a new sync arrives
  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && cnt_q == LAST && !start) |=> !busy_q);
  // R9: a sync held high does not start another frame
  assert_level_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_q && sync_i && sync_q) |=> !busy_q);
endmodule

// File: rtl/codec_frame_tx.sv
module codec_frame_tx
  import codec_tx_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sync_i,
  input  logic                        codec_ready_i,
  input  logic                        cmd_valid_i,
  input  logic                        cmd_read_i,
  input  logic [IDX_W-1:0]            cmd_index_i,
  input  logic [DATA_W-1:0]           reg_rdata_i,
  input  logic [MODE_W-1:0]           adc_mode_i,
  input  logic [NUM_CAP*SAMPLE_W-1:0] adc_samples_i,
  input  logic [NUM_CAP-1:0]          adc_valid_i,
  input  logic [GPIO_W-1:0]           gpio_pins_i,
  input  logic                        gpio_irq_i,
  input  logic                        gpio_valid_i,
  output logic                        sdata_o
);
  localparam int S1_MSB = FRAME_W - TAG_W - 1;

  logic [1:0]                rst_sync_q;
  logic                      rst_int_n;
  logic [NUM_CAP*SLOT_W-1:0] cap_slots;
  logic [NUM_CAP-1:0]        cap_tags;
  logic [FRAME_W-1:0]        frame_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  codec_cap_mux #(.NCAP(NUM_CAP), .SW(SAMPLE_W)) i_cap_mux (
    .mode_i   (adc_mode_i),
    .samples_i(adc_samples_i),
    .valid_i  (adc_valid_i),
    .slots_o  (cap_slots),
    .tags_o   (cap_tags)
  );

  codec_frame_build i_build (
    .ready_i     (codec_ready_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_read_i  (cmd_read_i),
    .index_i     (cmd_index_i),
    .rdata_i     (reg_rdata_i),
    .cap_slots_i (cap_slots),
    .cap_tags_i  (cap_tags),
    .gpio_i      (gpio_pins_i),
    .irq_i       (gpio_irq_i),
    .gpio_valid_i(gpio_valid_i),
    .frame_o     (frame_w)
  );

  codec_frame_shifter #(.FW(FRAME_W)) i_shifter (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .sync_i (sync_i),
    .frame_i(frame_w),
    .sdata_o(sdata_o)
  );

  // R6: the channel mapping is a permutation, so the valid count is kept
  assert_cap_tag_count_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(cap_tags) == $countones(adc_valid_i));
  // R5: a write or an absent command leaves slots 1 and 2 and their tags empty
  assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cmd_valid_i && cmd_read_i) |->
      (frame_w[FRAME_W-2 -: 2] == 2'b00 && frame_w[S1_MSB -: 2*SLOT_W] == '0));
  // R3: a read places the requested index in slot 1
  assert_read_index_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid_i && cmd_read_i) |-> frame_w[S1_MSB-1 -: IDX_W] == cmd_index_i);
  // R7: an invalid pin-status slot is all zero
  assert_gpio_quiet_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !gpio_valid_i |-> frame_w[SLOT_W-1:0] == '0);
endmodule

// File: tb/test_codec_frame_tx.sv
module test_codec_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, sync, rdy, cv, crd, irq, gv, sdata;
  logic [6:0]  idx;
  logic [15:0] dat;
  logic [1:0]  mode;
  logic [8:0][17:0] smp;
  logic [8:0]  vld;
  logic [9:0]  gp;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_frame_tx i_codec_frame_tx (
    .clk(clk), .rst_n(rst_n), .sync_i(sync), .codec_ready_i(rdy),
    .cmd_valid_i(cv), .cmd_read_i(crd), .cmd_index_i(idx), .reg_rdata_i(dat),
    .adc_mode_i(mode), .adc_samples_i(smp), .adc_valid_i(vld),
    .gpio_pins_i(gp), .gpio_irq_i(irq), .gpio_valid_i(gv), .sdata_o(sdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [255:0] exp_frame();
    logic [15:0] tg;
    logic [19:0] sl [12];
    logic [255:0] f;
    logic rd;
    rd = cv && crd;
    tg = '0;
    tg[15] = rdy; tg[14] = rd; tg[13] = rd;
    sl[0] = rd ? {1'b0, idx, 12'h000} : 20'h0;
    sl[1] = rd ? {dat, 4'h0} : 20'h0;
    for (int k = 0; k < 9; k++) begin
      int ch;
      ch = (k + int'(mode)) % 9;
      tg[12-k] = vld[ch];
      sl[2+k] = vld[ch] ? {smp[ch], 2'b00} : 20'h0;
    end
    tg[3] = gv;
    sl[11] = gv ? {gp, 9'h000, irq} : 20'h0;
    f[255:240] = tg;
    for (int s = 0; s < 12; s++) f[239-20*s -: 20] = sl[s];
    return f;
  endfunction

  // Sends one frame; sync held for 'hold' edges, inputs scrambled mid-frame when 'perturb'.
  task automatic run_frame(input int hold, input bit perturb, output logic [255:0] got);
    @(negedge clk);
    sync = 1'b1;
    @(negedge clk);
    check("R1 line low before first bit", 32'(sdata), 32'd0);
    if (hold == 1) sync = 1'b0;
    if (perturb) begin
      cv = ~cv; idx = ~idx; dat = ~dat; mode = mode + 2'd1;
    end
    for (int k = 1; k <= 256; k++) begin
      @(negedge clk);
      got[256-k] = sdata;
      if (k == hold - 1) sync = 1'b0;
      if (perturb && k == 100) begin
        rdy = ~rdy; vld = ~vld; gp = ~gp; irq = ~irq; gv = ~gv;
        for (int c = 0; c < 9; c++) smp[c] = 18'($urandom);
      end
    end
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      check("R1 idle after frame", 32'(sdata), 32'd0);
    end
  endtask

  task automatic cmp_frame(input logic [255:0] got, input logic [255:0] exp, input bit rd);
    check("R2 tag slot", 32'(got[255:240]), 32'(exp[255:240]));
    check(rd ? "R3 slot 1" : "R5 slot 1", 32'(got[239:220]), 32'(exp[239:220]));
    check(rd ? "R4 slot 2" : "R5 slot 2", 32'(got[219:200]), 32'(exp[219:200]));
    for (int k = 0; k < 9; k++)
      check($sformatf("R6 capture slot %0d", k + 3), 32'(got[199-20*k -: 20]), 32'(exp[199-20*k -: 20]));
    check("R7 slot 12", 32'(got[19:0]), 32'(exp[19:0]));
  endtask

  task automatic load_samples(input int seed);
    for (int c = 0; c < 9; c++) smp[c] = 18'((seed * 7919 + c * 4099 + 1) ^ (c << 14));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sync = 1'b0;
    rdy = 1'b0; cv = 1'b0; crd = 1'b0; idx = '0; dat = '0; mode = '0;
    smp = '0; vld = '0; gp = '0; irq = 1'b0; gv = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset output", 32'(sdata), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", 32'(sdata), 32'd0);
  endtask

  task automatic t_read_frame();
    logic [255:0] got, exp;
    rdy = 1'b1; cv = 1'b1; crd = 1'b1; idx = 7'h5E; dat = 16'hBEEF; mode = 2'd0;
    load_samples(1); vld = 9'h1FF; gp = 10'h2A5; irq = 1'b1; gv = 1'b1;
    exp = exp_frame();
    run_frame(1, 1'b0, got);
    cmp_frame(got, exp, 1'b1);
  endtask

  task automatic t_write_frame();
    logic [255:0] got, exp;
    rdy = 1'b1; cv = 1'b1; crd = 1'b0; idx = 7'h52; dat = 16'h1234; mode = 2'd1;
    load_samples(2); vld = 9'b101100110; gp = 10'h155; irq = 1'b0; gv = 1'b0;
    exp = exp_frame();
    run_frame(1, 1'b0, got);
    cmp_frame(got, exp, 1'b0);
  endtask

  task automatic t_modes_nocmd();
    logic [255:0] got, exp;
    for (int m = 2; m < 4; m++) begin
      rdy = (m == 3); cv = 1'b0; crd = 1'b1; idx = 7'h7F; dat = 16'hFFFF; mode = 2'(m);
      load_samples(m + 5); vld = 9'b010011101 ^ 9'(m); gp = 10'h3C1; irq = 1'b1; gv = 1'b1;
      exp = exp_frame();
      run_frame(1, 1'b0, got);
      cmp_frame(got, exp, 1'b0);
    end
  endtask

  task automatic t_capture_hold();
    logic [255:0] got, exp;
    rdy = 1'b1; cv = 1'b1; crd = 1'b1; idx = 7'h26; dat = 16'h8001; mode = 2'd3;
    load_samples(9); vld = 9'b111000111; gp = 10'h0F0; irq = 1'b0; gv = 1'b1;
    exp = exp_frame();
    run_frame(1, 1'b1, got);
    check("R8 whole frame low half", got[31:0], exp[31:0]);
    check("R8 whole frame tag and slot 1", got[255:224], exp[255:224]);
    cmp_frame(got, exp, 1'b1);
  endtask

  task automatic t_sync_level();
    logic [255:0] got, exp;
    rdy = 1'b0; cv = 1'b1; crd = 1'b1; idx = 7'h01; dat = 16'h00A5; mode = 2'd2;
    load_samples(13); vld = 9'h0AA; gp = 10'h001; irq = 1'b1; gv = 1'b0;
    exp = exp_frame();
    run_frame(5, 1'b0, got);
    check("R9 held sync gives one aligned frame", got[255:224], exp[255:224]);
    cmp_frame(got, exp, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_read_frame();
    t_write_frame();
    t_modes_nocmd();
    t_capture_hold();
    t_sync_level();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule